// File: doc/BRIEF.md
# Capability Record Chain Walker

This block parses a chain of capability records held in a word-addressed register memory. Each record starts with one 32-bit header word, and the header may be followed by value words. The walk begins at a fixed byte offset when a start pulse arrives. The walker reads each header through a simple synchronous read port and classifies the record. It latches the values of the record types it recognises, then jumps to the next record.

The walk ends in one of two ways. An end-of-chain record raises `done_o`. A malformed or forbidden record raises `err_o`, and so does running out of memory. If the first header word is zero, there is no chain: the walk finishes at once with `done_o`. Both flags and all captured values stay put until the next accepted start.

The block carries no streamed data. The read port has no back-pressure: the memory answers every read exactly one cycle later. For that reason every pin is a plain control or status pin, and there is no valid/ready pair.

Top module: `tlv_walker`

## Requirements
- R1: A header word holds a must-understand flag in bit 31, a type in bits 30:16 and a value length in bytes in bits 15:0. The length does not include the 4-byte header, so the next header sits at the current byte offset plus 4 plus the length.
- R2: If the word at the base offset is all zero, the walk ends with `done_o`=1 and `err_o`=0. Every capability output stays zero.
- R3: A header of type 2 ends the walk with `done_o`=1, whatever its length. No further read is issued.
- R4: A header of type 0 ends the walk with `err_o`=1. This includes a nonzero first word whose type is 0.
- R5: A length that is not a multiple of 4 ends the walk with `err_o`=1.
- R6: Type 1 records are skipped by their length, whatever their flag. A record of any other unrecognised type is skipped when bit 31 is clear. When bit 31 is set, it ends the walk with `err_o`=1.
- R7: For type 3, type 7 and type 10 records, the first value word goes to `freq_o`, `cap_o` or `msg_types_o` respectively. A zero length on any of these types ends the walk with `err_o`=1.
- R8: A type 4 record latches two values without reading its body. `mbox_off_o` takes the byte offset just past its header, and `mbox_len_o` takes its length.
- R9: The walk ends with `err_o`=1 in two cases: a record whose end would pass the memory size (4·2^ADDR_W bytes), or a walk that reaches that size without a type 2 header. A type 2 header in the last word is legal.
- R10: The memory returns data one cycle after `rd_en_o`. Each header costs 2 cycles and each value read costs 2 more. The flags appear exactly that many cycles after the start is sampled, and `busy_o` is high in between.
- R11: An accepted start clears both flags and all capability outputs. A start that arrives while busy is ignored. `done_o` and `err_o` are never high together, and both hold while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse; accepted only when idle |
| rd_en_o | output | 1 | Memory read strobe |
| rd_addr_o | output | ADDR_W | Word address of the read |
| rd_data_i | input | 32 | Read data, valid the cycle after `rd_en_o` |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | Walk ended at an end marker or absent chain |
| err_o | output | 1 | Walk aborted on a malformed chain |
| freq_o | output | 32 | Captured type 3 value |
| cap_o | output | 32 | Captured type 7 value |
| msg_types_o | output | 32 | First word of the type 10 bitmap |
| mbox_off_o | output | ADDR_W+2 | Byte offset of the type 4 region |
| mbox_len_o | output | 16 | Byte length of the type 4 region |

## Verification
A behavioural model in the bench walks the same memory image and predicts a latency L: two cycles per header and two more per value word. Counting from the edge that samples the start, the bench compares `busy_o` on every following clock, expecting it high up to edge L-1 and low after edge L. At edge L it also checks the flags and every capture output. All sampling happens on the falling edge, so each check lands in the cycle after the register that drives it has updated. The read strobes are counted over the same window and must equal L/2, which shows that no read happens after the walk ends.

// File: rtl/tlv_walk_pkg.sv
`timescale 1ns/1ps
package tlv_walk_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_HREQ, ST_HWAIT, ST_VREQ, ST_VWAIT} walk_st_e;
  typedef enum logic [2:0] {CL_DONE, CL_FAIL, CL_SKIP, CL_VALUE, CL_MBOX} rec_cls_e;

  localparam int unsigned NSLOT = 3;
  typedef enum logic [1:0] {SL_FREQ = 2'd0, SL_CAP = 2'd1, SL_MSG = 2'd2} slot_e;

  localparam logic [14:0] TY_ILLEGAL = 15'd0;
  localparam logic [14:0] TY_PAD     = 15'd1;
  localparam logic [14:0] TY_END     = 15'd2;
  localparam logic [14:0] TY_FREQ    = 15'd3;
  localparam logic [14:0] TY_MBOX    = 15'd4;
  localparam logic [14:0] TY_CAP     = 15'd7;
  localparam logic [14:0] TY_MSG     = 15'd10;

  // width able to hold offset + 4 + a 16-bit length without wrapping
  function automatic int unsigned ext_w(int unsigned addr_w);
    return (((addr_w + 2) > 16) ? (addr_w + 2) : 16) + 1;
  endfunction
endpackage

// File: rtl/tlv_hdr_decode.sv
`timescale 1ns/1ps
module tlv_hdr_decode
  import tlv_walk_pkg::*;
#(
  parameter  int unsigned ADDR_W = 8,
  localparam int unsigned OFF_W  = ADDR_W + 2,
  localparam int unsigned EXT_W  = ext_w(ADDR_W)
) (
  input  logic [31:0]      hdr_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic             first_i,
  output rec_cls_e         cls_o,
  output slot_e            slot_o,
  output logic [OFF_W-1:0] nxt_o,
  output logic             at_lim_o
);
  localparam logic [EXT_W-1:0] MEM_LIM = EXT_W'(1) << OFF_W;

  logic        must_know;
  logic [14:0] kind;
  logic [15:0] vlen;
  logic [EXT_W-1:0] nxt_ext;
  logic        overrun;

  // R1: field split and next-record arithmetic
  assign must_know = hdr_i[31];
  assign kind      = hdr_i[30:16];
  assign vlen      = hdr_i[15:0];
  assign nxt_ext   = EXT_W'(off_i) + EXT_W'(4) + EXT_W'(vlen);
  assign overrun   = nxt_ext > MEM_LIM;            // R9
  assign at_lim_o  = nxt_ext == MEM_LIM;           // R9
  assign nxt_o     = nxt_ext[OFF_W-1:0];

  always_comb begin
    cls_o  = CL_SKIP;
    slot_o = SL_FREQ;
    if (first_i && (hdr_i == 32'd0)) begin
      cls_o = CL_DONE;                              // R2
    end else if (kind == TY_ILLEGAL) begin
      cls_o = CL_FAIL;                              // R4
    end else if (kind == TY_END) begin
      cls_o = CL_DONE;                              // R3
    end else if (vlen[1:0] != 2'b00) begin
      cls_o = CL_FAIL;                              // R5
    end else if (overrun) begin
      cls_o = CL_FAIL;                              // R9
    end else begin
      unique case (kind)
        TY_FREQ, TY_CAP, TY_MSG: begin              // R7
          cls_o  = (vlen == 16'd0) ? CL_FAIL : CL_VALUE;
          slot_o = (kind == TY_FREQ) ? SL_FREQ :
                   (kind == TY_CAP)  ? SL_CAP  : SL_MSG;
        end
        TY_MBOX: cls_o = CL_MBOX;                   // R8
        TY_PAD:  cls_o = CL_SKIP;                   // R6
        default: cls_o = must_know ? CL_FAIL : CL_SKIP;
      endcase
    end
  end
endmodule

// File: rtl/tlv_walk_ctrl.sv
`timescale 1ns/1ps
module tlv_walk_ctrl
  import tlv_walk_pkg::*;
#(
  parameter  int unsigned ADDR_W   = 8,
  parameter  int unsigned BASE_OFF = 88,
  localparam int unsigned OFF_W    = ADDR_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [OFF_W-1:0]  off_o,
  output logic              first_o,
  input  rec_cls_e          cls_i,
  input  slot_e             slot_i,
  input  logic [OFF_W-1:0]  nxt_i,
  input  logic              at_lim_i,
  output logic              clr_o,
  output logic              val_ld_o,
  output slot_e             val_sel_o,
  output logic              mb_ld_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  localparam logic [OFF_W-1:0] BASE = OFF_W'(BASE_OFF);

  walk_st_e         st_q;
  logic [OFF_W-1:0] off_q, nxt_q;
  logic             first_q, lim_q, done_q, err_q;
  slot_e            slot_q;
  logic [ADDR_W-1:0] word_q;

  assign word_q    = off_q[OFF_W-1:2];
  assign rd_en_o   = (st_q == ST_HREQ) || (st_q == ST_VREQ);
  assign rd_addr_o = (st_q == ST_VREQ) ? word_q + ADDR_W'(1) : word_q;
  assign off_o     = off_q;
  assign first_o   = first_q;
  assign clr_o     = (st_q == ST_IDLE) && start_i;
  assign val_ld_o  = st_q == ST_VWAIT;
  assign val_sel_o = slot_q;
  assign mb_ld_o   = (st_q == ST_HWAIT) && (cls_i == CL_MBOX);
  assign busy_o    = st_q != ST_IDLE;
  assign done_o    = done_q;
  assign err_o     = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      off_q   <= '0;
      nxt_q   <= '0;
      first_q <= 1'b0;
      lim_q   <= 1'b0;
      slot_q  <= SL_FREQ;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin               // R11
          off_q   <= BASE;
          first_q <= 1'b1;
          done_q  <= 1'b0;
          err_q   <= 1'b0;
          st_q    <= ST_HREQ;
        end
        ST_HREQ: st_q <= ST_HWAIT;                 // R10
        ST_HWAIT: begin
          first_q <= 1'b0;
          unique case (cls_i)
            CL_DONE: begin done_q <= 1'b1; st_q <= ST_IDLE; end
            CL_FAIL: begin err_q  <= 1'b1; st_q <= ST_IDLE; end
            CL_VALUE: begin
              slot_q <= slot_i;
              nxt_q  <= nxt_i;
              lim_q  <= at_lim_i;
              st_q   <= ST_VREQ;
            end
            default: begin
              if (at_lim_i) begin err_q <= 1'b1; st_q <= ST_IDLE; end
              else begin off_q <= nxt_i; st_q <= ST_HREQ; end
            end
          endcase
        end
        ST_VREQ: st_q <= ST_VWAIT;
        ST_VWAIT: begin
          if (lim_q) begin err_q <= 1'b1; st_q <= ST_IDLE; end
          else begin off_q <= nxt_q; st_q <= ST_HREQ; end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tlv_cap_regs.sv
`timescale 1ns/1ps
module tlv_cap_regs
  import tlv_walk_pkg::*;
#(
  parameter  int unsigned ADDR_W = 8,
  localparam int unsigned OFF_W  = ADDR_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             val_ld_i,
  input  slot_e            val_sel_i,
  input  logic [31:0]      data_i,
  input  logic             mb_ld_i,
  input  logic [OFF_W-1:0] hdr_off_i,
  output logic [31:0]      slot_o [NSLOT],
  output logic [OFF_W-1:0] mb_off_o,
  output logic [15:0]      mb_len_o
);
  // R7: one capture register per single-word record type
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic [31:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n || clr_i)                               q <= '0;
      else if (val_ld_i && (val_sel_i == slot_e'(g)))    q <= data_i;
    end
    assign slot_o[g] = q;
  end

  // R8: region offset points past the header; length comes from the header
  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      mb_off_o <= '0;
      mb_len_o <= '0;
    end else if (mb_ld_i) begin
      mb_off_o <= hdr_off_i + OFF_W'(4);
      mb_len_o <= data_i[15:0];
    end
  end
endmodule

// File: rtl/tlv_walker.sv
`timescale 1ns/1ps
module tlv_walker
  import tlv_walk_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned BASE_OFF = 88
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [31:0]       rd_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [31:0]       freq_o,
  output logic [31:0]       cap_o,
  output logic [31:0]       msg_types_o,
  output logic [ADDR_W+1:0] mbox_off_o,
  output logic [15:0]       mbox_len_o
);
  localparam int unsigned OFF_W = ADDR_W + 2;

  logic [OFF_W-1:0] cur_off, nxt_off;
  logic             first_rec, at_lim;
  rec_cls_e         cls;
  slot_e            slot, val_sel;
  logic             clr, val_ld, mb_ld;
  logic [31:0]      slots [NSLOT];

  tlv_hdr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .hdr_i(rd_data_i), .off_i(cur_off), .first_i(first_rec),
    .cls_o(cls), .slot_o(slot), .nxt_o(nxt_off), .at_lim_o(at_lim)
  );

  tlv_walk_ctrl #(.ADDR_W(ADDR_W), .BASE_OFF(BASE_OFF)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o),
    .off_o(cur_off), .first_o(first_rec),
    .cls_i(cls), .slot_i(slot), .nxt_i(nxt_off), .at_lim_i(at_lim),
    .clr_o(clr), .val_ld_o(val_ld), .val_sel_o(val_sel), .mb_ld_o(mb_ld),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  tlv_cap_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .clr_i(clr),
    .val_ld_i(val_ld), .val_sel_i(val_sel), .data_i(rd_data_i),
    .mb_ld_i(mb_ld), .hdr_off_i(cur_off),
    .slot_o(slots), .mb_off_o(mbox_off_o), .mb_len_o(mbox_len_o)
  );

  assign freq_o      = slots[SL_FREQ];
  assign cap_o       = slots[SL_CAP];
  assign msg_types_o = slots[SL_MSG];
endmodule

// File: rtl/tlv_walker_chk.sv
`timescale 1ns/1ps
module tlv_walker_chk #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              rd_en_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic [31:0]       freq_o,
  input logic [31:0]       cap_o,
  input logic [31:0]       msg_types_o,
  input logic [ADDR_W+1:0] mbox_off_o
);
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(done_o && err_o)); // R11
  AST_READ_GAP: assert property (@(posedge clk) disable iff (!rst_n) rd_en_o |=> !rd_en_o); // R10
  AST_READ_BUSY: assert property (@(posedge clk) disable iff (!rst_n) rd_en_o |-> busy_o); // R3
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) (start_i && !busy_o) |=> busy_o); // R10
  AST_END_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy_o) |-> (done_o || err_o)); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!busy_o && !start_i) |=> ($stable(done_o) && $stable(err_o) && $stable(freq_o) && $stable(cap_o) && $stable(msg_types_o))); // R11
  AST_MBOX_ALIGN: assert property (@(posedge clk) disable iff (!rst_n) mbox_off_o[1:0] == 2'b00); // R8
endmodule

bind tlv_walker tlv_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_en_o(rd_en_o),
  .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .freq_o(freq_o),
  .cap_o(cap_o), .msg_types_o(msg_types_o), .mbox_off_o(mbox_off_o)
);

// File: tb/tlv_walker_bench.sv
`timescale 1ns/1ps
module tlv_walker_bench;
  localparam int unsigned AW   = 8;
  localparam int unsigned BASE = 88;
  localparam int unsigned MEMB = 4 << AW;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic rd_en, busy, done, err;
  logic [AW-1:0] rd_addr;
  logic [31:0] rd_data = '0, freq, cap, msg;
  logic [AW+1:0] mbox_off;
  logic [15:0] mbox_len;
  logic [31:0] mem [0:(1<<AW)-1];
  int checks = 0, fails = 0;

  always #5 clk = ~clk;
  always_ff @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

  tlv_walker #(.ADDR_W(AW), .BASE_OFF(BASE)) u_tlv_walker (
    .clk(clk), .rst_n(rst_n), .start_i(start), .rd_en_o(rd_en),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data), .busy_o(busy), .done_o(done),
    .err_o(err), .freq_o(freq), .cap_o(cap), .msg_types_o(msg),
    .mbox_off_o(mbox_off), .mbox_len_o(mbox_len)
  );

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
  endtask

  task automatic put(int boff, logic [31:0] w);
    mem[boff / 4] = w;
  endtask

  // behavioural walk over the bench memory: R1..R10
  task automatic model(output int lat, output bit e_done, output bit e_err,
                       output logic [31:0] e_freq, output logic [31:0] e_cap,
                       output logic [31:0] e_msg, output int e_moff, output int e_mlen);
    int off, n, t;
    bit first, run;
    logic [31:0] w;
    off = BASE; first = 1; run = 1; lat = 0;
    e_done = 0; e_err = 0; e_freq = 0; e_cap = 0; e_msg = 0; e_moff = 0; e_mlen = 0;
    while (run) begin
      w = mem[off / 4];
      lat += 2;
      t = int'(w[30:16]);
      n = int'(w[15:0]);
      if (first && w == 0) begin e_done = 1; run = 0; end
      else if (t == 0) begin e_err = 1; run = 0; end
      else if (t == 2) begin e_done = 1; run = 0; end
      else if (n % 4 != 0) begin e_err = 1; run = 0; end
      else if (off + 4 + n > MEMB) begin e_err = 1; run = 0; end
      else begin
        if (t == 3 || t == 7 || t == 10) begin
          if (n == 0) begin e_err = 1; run = 0; end
          else begin
            lat += 2;
            if (t == 3) e_freq = mem[off / 4 + 1];
            else if (t == 7) e_cap = mem[off / 4 + 1];
            else e_msg = mem[off / 4 + 1];
          end
        end else if (t == 4) begin
          e_moff = off + 4; e_mlen = n;
        end else if (t != 1 && w[31]) begin
          e_err = 1; run = 0;
        end
        if (run) begin
          off = off + 4 + n;
          if (off == MEMB) begin e_err = 1; run = 0; end
        end
      end
      first = 0;
    end
  endtask

  task automatic run_walk(string req, int extra_start);
    int lat, moff, mlen, reads;
    bit d, e;
    logic [31:0] f, c, m;
    model(lat, d, e, f, c, m, moff, mlen);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;      // after the edge that sampled start
    reads = rd_en ? 1 : 0;
    for (int i = 1; i <= lat; i++) begin
      start = (i == extra_start);       // R11: ignored while busy
      @(negedge clk);
      chk(busy == (i < lat), req, $sformatf("busy at cycle %0d", i), busy, i < lat);
      if (i < lat && rd_en) reads++;
    end
    start = 1'b0;
    chk(done == d, req, "done", done, d);
    chk(err == e, req, "err", err, e);
    chk(freq == f, req, "freq", freq, f);
    chk(cap == c, req, "cap", cap, c);
    chk(msg == m, req, "msg types", msg, m);
    chk(int'(mbox_off) == moff, req, "mbox offset", mbox_off, moff);
    chk(int'(mbox_len) == mlen, req, "mbox length", mbox_len, mlen);
    chk(reads == lat / 2, req, "read count", reads, lat / 2);   // R3 R10
    @(negedge clk);
    chk(done == d && err == e, req, "flags held idle", {done, err}, {d, e});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !err && !rd_en, "R11", "reset flags", {busy, done, err, rd_en}, 0);
    chk(freq == 0 && cap == 0 && msg == 0 && mbox_len == 0, "R11", "reset values", freq, 0);

    // R1 R6 R7 R8: full chain with every recognised type, extra start mid-walk (R11)
    clear_mem();
    put(88, 32'h0003_0004);  put(92, 32'h0000_012C);
    put(96, 32'h0007_0004);  put(100, 32'hCAFE_0001);
    put(104, 32'h0004_0010); put(108, 32'h1111_1111);
    put(124, 32'h0001_0008);
    put(136, 32'h0055_0008);
    put(148, 32'h000A_0008); put(152, 32'h0000_00A5); put(156, 32'hFFFF_0000);
    put(160, 32'h0002_0000);
    run_walk("R7", 3);

    // R2 absent chain (also shows start clears earlier values)
    clear_mem();
    run_walk("R2", 0);

    // R4 illegal type mid-chain, and a nonzero first word of type 0
    clear_mem();
    put(88, 32'h0003_0004); put(92, 32'h0000_0042); put(96, 32'h0000_0008);
    run_walk("R4", 0);
    clear_mem();
    put(88, 32'h0000_0004);
    run_walk("R4", 0);

    // R5 length not a multiple of four
    clear_mem();
    put(88, 32'h0001_0006);
    run_walk("R5", 0);

    // R6 unknown type with flag set fails; padding with flag set is skipped
    clear_mem();
    put(88, 32'h8055_0004);
    run_walk("R6", 0);
    clear_mem();
    put(88, 32'h8001_0004); put(96, 32'h0002_0000);
    run_walk("R6", 0);

    // R7 zero-length value record
    clear_mem();
    put(88, 32'h0007_0000);
    run_walk("R7", 0);

    // R9 overrun, huge length, exact fill without end, end in last word
    clear_mem();
    put(88, 32'h0001_03A8);
    run_walk("R9", 0);
    clear_mem();
    put(88, 32'h0001_FFFC);
    run_walk("R9", 0);
    clear_mem();
    put(88, 32'h0001_03A4);
    run_walk("R9", 0);
    clear_mem();
    put(88, 32'h0001_03A0); put(1020, 32'h0002_0000);
    run_walk("R9", 0);

    // R3 end marker with nonzero length, value record before it
    clear_mem();
    put(88, 32'h000A_0004); put(92, 32'h0000_0F0F); put(96, 32'h0002_0010);
    put(100, 32'h0000_0000);
    run_walk("R3", 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule